// File: doc/BRIEF.md
# LCD Sync Timing Generator

This block produces the raster timing for a panel: a horizontal sync, a vertical sync, a display-enable window and a sticky vertical-retrace status with an optional interrupt. All timing advances on a pixel-clock enable (`pix_ce`), so the block runs on the system clock while the pixel rate is set elsewhere. Clock selection, pixel fetch and panel power are handled outside this block.

Software programs the geometry through a simple register write port. Each register is 16 bits wide and holds packed fields. Every field is stored as its value minus one. Horizontal quantities are counted in characters of 8 pixels. Vertical quantities are counted in lines. In both directions the sync start is the active size plus the front porch, and the total is the sync start plus the sync width plus the back porch.

A run control holds the raster at its origin while geometry is changed. The retrace status latches on the first line of vertical sync and stays set until software clears it. All pins are plain control and status signals. There is no data stream and no handshake.

Top module: `lcd_sync_gen`

## Requirements
- R1: After reset the design is in this state: `de_o`, `hsync_o`, `vsync_o`, `vint_status_o` and `vint_irq_o` are all 0, and every configuration field is 0, including the run bit.
- R2: The raster position advances only on clock edges where `pix_ce` is 1. Each character lasts exactly 8 such edges. With `pix_ce` at 0 the position, and so every timing output, holds.
- R3: Register address 0 holds two fields. Bits [7:0] hold the line total in characters minus one. Bits [15:8] hold the active width in characters minus one. The character counter wraps to 0 after the total has been reached.
- R4: Register address 1 holds two fields. Bits [7:0] hold the horizontal sync start character minus one. Bits [15:12] hold the sync width in characters minus one. The horizontal sync is active for characters start through start+width−1.
- R5: Register address 2, bits [11:0], holds the active line count minus one. Register address 3, bits [11:0], holds the total line count minus one. The line counter wraps to 0 after the last line of the total.
- R6: Register address 4 holds two fields. Bits [11:0] hold the vertical sync start line minus one. Bits [15:12] hold the sync width in lines minus one. The vertical sync is active for lines start through start+width−1.
- R7: `de_o` is 1 only while the character is inside the active width and the line is inside the active height.
- R8: In the control register (address 5), bit 0 inverts `hsync_o` and bit 1 inverts `vsync_o`, which gives active-low sync.
- R9: `vint_status_o` becomes 1 on the edge that moves the raster onto the first line of vertical sync. Once set, it stays set.
- R10: A write to address 6 with bit 0 equal to 0 clears the status. A write with bit 0 equal to 1 leaves it unchanged. A retrace event on the same edge as a clear wins.
- R11: `vint_irq_o` equals the status ANDed with control bit 2, the interrupt enable.
- R12: When control bit 3 (run) is 0, the raster returns to its origin and stays there. `de_o` is 0 and both syncs sit at their inactive level. When run is set again, the raster restarts at character 0, line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_ce | input | 1 | Pixel-clock enable; the raster advances one pixel per edge where it is high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| hsync_o | output | 1 | Horizontal sync, with polarity applied |
| vsync_o | output | 1 | Vertical sync, with polarity applied |
| de_o | output | 1 | Display enable |
| vint_status_o | output | 1 | Sticky vertical-retrace status |
| vint_irq_o | output | 1 | Retrace interrupt, gated by its enable |

## Verification
A scoreboard predicts every output after each pixel step and each write, using a position model that works from the minus-one field encodings. An off-by-one in any start, width or total field therefore shows up as a sync, enable or status edge one character or one line early or late. The bench measures how long it takes to reach the first retrace from the origin, for two different geometries. A counter that wraps at the wrong value, or a status that is set on the wrong line, changes that count.

The bench also checks the status behaviour, an idle stretch mid-line, and stopping mid-frame:
- It issues a clear write with bit 0 set and one with bit 0 cleared. A design that decodes the clear wrongly keeps or drops the status in the wrong case.
- It turns the interrupt enable off and on around the status. A missing gate raises the interrupt without the enable.
- It holds `pix_ce` low for a long stretch mid-line. A design that counts on the system clock loses the enable window there.
- It stops the raster mid-frame and restarts it. A design that only pauses, instead of returning to the origin, reaches its retrace at the wrong time after the restart.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;
  localparam int REG_AW    = 3;
  localparam int REG_DW    = 16;
  localparam int HCH_W     = 8;   // character counter / horizontal field width
  localparam int VLN_W     = 12;  // line counter / vertical field width
  localparam int SW_W      = 4;   // sync width field width
  localparam int HACT_LSB  = 8;   // active-width field position in address 0
  localparam int SWID_LSB  = 12;  // sync-width field position in addresses 1 and 4
  localparam int PIX_PER_CH = 8;

  typedef enum logic [REG_AW-1:0] {
    RA_HTIM = 3'd0,
    RA_HSYN = 3'd1,
    RA_VACT = 3'd2,
    RA_VTOT = 3'd3,
    RA_VSYN = 3'd4,
    RA_CTRL = 3'd5,
    RA_STAT = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic [HCH_W-1:0] h_total_m1;
    logic [HCH_W-1:0] h_act_m1;
    logic [HCH_W-1:0] h_sstart_m1;
    logic [SW_W-1:0]  h_swidth_m1;
    logic [VLN_W-1:0] v_total_m1;
    logic [VLN_W-1:0] v_act_m1;
    logic [VLN_W-1:0] v_sstart_m1;
    logic [SW_W-1:0]  v_swidth_m1;
    logic             hs_inv;
    logic             vs_inv;
    logic             irq_en;
    logic             run;
  } timing_cfg_t;
endpackage

// File: rtl/lcd_sync_regs.sv
module lcd_sync_regs
  import lcd_sync_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  input  logic              retrace_evt,
  output timing_cfg_t       cfg,
  output logic              status
);
  timing_cfg_t cfg_q;
  logic        status_q;
  logic        clr_wr;

  assign clr_wr = wr && (addr == RA_STAT) && !wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr) begin
      case (addr)
        RA_HTIM: begin
          cfg_q.h_total_m1 <= wdata[HCH_W-1:0];
          cfg_q.h_act_m1   <= wdata[HACT_LSB +: HCH_W];
        end
        RA_HSYN: begin
          cfg_q.h_sstart_m1 <= wdata[HCH_W-1:0];
          cfg_q.h_swidth_m1 <= wdata[SWID_LSB +: SW_W];
        end
        RA_VACT: cfg_q.v_act_m1   <= wdata[VLN_W-1:0];
        RA_VTOT: cfg_q.v_total_m1 <= wdata[VLN_W-1:0];
        RA_VSYN: begin
          cfg_q.v_sstart_m1 <= wdata[VLN_W-1:0];
          cfg_q.v_swidth_m1 <= wdata[SWID_LSB +: SW_W];
        end
        RA_CTRL: begin
          cfg_q.hs_inv <= wdata[0];
          cfg_q.vs_inv <= wdata[1];
          cfg_q.irq_en <= wdata[2];
          cfg_q.run    <= wdata[3];
        end
        default: ;
      endcase
    end
  end

  // retrace event has priority over a software clear on the same edge
  always_ff @(posedge clk) begin
    if (!rst_n)           status_q <= 1'b0;
    else if (retrace_evt) status_q <= 1'b1;
    else if (clr_wr)      status_q <= 1'b0;
  end

  assign cfg    = cfg_q;
  assign status = status_q;

  a_r9_status_set: assert property (@(posedge clk) disable iff (!rst_n)
    retrace_evt |=> status_q);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !clr_wr) |=> status_q);
endmodule

// File: rtl/lcd_sync_counter.sv
module lcd_sync_counter #(
  parameter int H_W  = 8,
  parameter int V_W  = 12,
  parameter int PPC  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pix_ce,
  input  logic           run,
  input  logic [H_W-1:0] h_total_m1,
  input  logic [V_W-1:0] v_total_m1,
  input  logic [V_W-1:0] v_sstart_m1,
  output logic [H_W-1:0] h_pos,
  output logic [V_W-1:0] v_pos,
  output logic           retrace_evt
);
  localparam int SUB_W = (PPC > 1) ? $clog2(PPC) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(PPC - 1);
  localparam logic [V_W:0]     V_ONE    = (V_W+1)'(1);

  logic [SUB_W-1:0] sub_q;
  logic [H_W-1:0]   h_q;
  logic [V_W-1:0]   v_q;
  logic             char_done, line_done;
  logic [V_W-1:0]   v_next;

  assign char_done = pix_ce && (sub_q == SUB_LAST);
  assign line_done = char_done && (h_q >= h_total_m1);
  assign v_next    = (v_q >= v_total_m1) ? '0 : v_q + 1'b1;
  assign retrace_evt = run && line_done &&
                       ({1'b0, v_next} == ({1'b0, v_sstart_m1} + V_ONE));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      sub_q <= '0;
      h_q   <= '0;
      v_q   <= '0;
    end else begin
      if (pix_ce)    sub_q <= char_done ? '0 : sub_q + 1'b1;
      if (char_done) h_q   <= line_done ? '0 : h_q + 1'b1;
      if (line_done) v_q   <= v_next;
    end
  end

  assign h_pos = h_q;
  assign v_pos = v_q;

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !pix_ce) |=> ($stable(sub_q) && $stable(h_q) && $stable(v_q)));

  a_r12_origin: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (sub_q == '0 && h_q == '0 && v_q == '0));
endmodule

// File: rtl/lcd_sync_axis.sv
module lcd_sync_axis #(
  parameter int W  = 8,
  parameter int SW = 4
) (
  input  logic          en,
  input  logic [W-1:0]  pos,
  input  logic [W-1:0]  act_m1,
  input  logic [W-1:0]  sstart_m1,
  input  logic [SW-1:0] swidth_m1,
  input  logic          inv,
  output logic          in_active,
  output logic          sync_o
);
  localparam logic [W:0] ONE = (W+1)'(1);

  logic [W:0] sync_last;
  logic       in_sync;

  // the field holds start-1, so the first sync unit is sstart_m1+1
  assign sync_last = {1'b0, sstart_m1} + {{(W+1-SW){1'b0}}, swidth_m1} + ONE;
  assign in_sync   = (pos > sstart_m1) && ({1'b0, pos} <= sync_last);
  assign in_active = en && (pos <= act_m1);
  assign sync_o    = (en && in_sync) ^ inv;
endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcd_sync_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_ce,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              vint_status_o,
  output logic              vint_irq_o
);
  timing_cfg_t      cfg;
  logic             status;
  logic             retrace_evt;
  logic [HCH_W-1:0] h_pos;
  logic [VLN_W-1:0] v_pos;
  logic             h_act, v_act;

  lcd_sync_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .retrace_evt(retrace_evt), .cfg(cfg), .status(status)
  );

  lcd_sync_counter #(.H_W(HCH_W), .V_W(VLN_W), .PPC(PIX_PER_CH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .run(cfg.run),
    .h_total_m1(cfg.h_total_m1), .v_total_m1(cfg.v_total_m1),
    .v_sstart_m1(cfg.v_sstart_m1),
    .h_pos(h_pos), .v_pos(v_pos), .retrace_evt(retrace_evt)
  );

  lcd_sync_axis #(.W(HCH_W), .SW(SW_W)) u_h_axis (
    .en(cfg.run), .pos(h_pos), .act_m1(cfg.h_act_m1),
    .sstart_m1(cfg.h_sstart_m1), .swidth_m1(cfg.h_swidth_m1),
    .inv(cfg.hs_inv), .in_active(h_act), .sync_o(hsync_o)
  );

  lcd_sync_axis #(.W(VLN_W), .SW(SW_W)) u_v_axis (
    .en(cfg.run), .pos(v_pos), .act_m1(cfg.v_act_m1),
    .sstart_m1(cfg.v_sstart_m1), .swidth_m1(cfg.v_swidth_m1),
    .inv(cfg.vs_inv), .in_active(v_act), .sync_o(vsync_o)
  );

  assign de_o          = h_act && v_act;
  assign vint_status_o = status;
  assign vint_irq_o    = status && cfg.irq_en;

  a_r12_de_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.run |-> !de_o);

  a_r11_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    vint_irq_o |-> vint_status_o);

  a_r7_de_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (de_o && pix_ce && cfg.run) |=> (de_o || !$stable(h_pos) || !$stable(v_pos)));
endmodule

// File: tb/lcd_sync_gen_bench.sv
module lcd_sync_gen_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, pix_ce, reg_wr;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic        hsync_o, vsync_o, de_o, vint_status_o, vint_irq_o;

  lcd_sync_gen u_lcd_sync_gen (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .hsync_o(hsync_o),
    .vsync_o(vsync_o), .de_o(de_o), .vint_status_o(vint_status_o),
    .vint_irq_o(vint_irq_o)
  );

  typedef struct {bit de; bit hs; bit vs; bit st; bit irq;} exp_t;
  exp_t q[$];

  int checks = 0, failures = 0;
  int mpx = 0, mhc = 0, mlc = 0;
  bit mst = 0;
  int mha = 0, mht = 0, mhs = 0, mhw = 0, mva = 0, mvt = 0, mvs = 0, mvw = 0;
  bit mih = 0, miv = 0, mie = 0, mrun = 0;
  int de_cnt = 0, hs_cnt = 0, vs_cnt = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic exp_t model_out();
    exp_t e;
    bit ha, va;
    e.de = mrun && (mhc <= mha) && (mlc <= mva);
    ha   = mrun && (mhc > mhs) && (mhc <= mhs + mhw + 1);
    va   = mrun && (mlc > mvs) && (mlc <= mvs + mvw + 1);
    e.hs = ha ^ mih;
    e.vs = va ^ miv;
    e.st = mst;
    e.irq = mst && mie;
    return e;
  endfunction

  function automatic void advance();
    int nl;
    if (!mrun) begin mpx = 0; mhc = 0; mlc = 0; return; end
    if (mpx == 7) begin
      mpx = 0;
      if (mhc >= mht) begin
        mhc = 0;
        nl = (mlc >= mvt) ? 0 : mlc + 1;
        if (nl == mvs + 1) mst = 1;
        mlc = nl;
      end else mhc++;
    end else mpx++;
  endfunction

  // monitor: compares every pushed expectation at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("R7 de", de_o, e.de);
      chk("R4/R8 hsync", hsync_o, e.hs);
      chk("R6/R8 vsync", vsync_o, e.vs);
      chk("R9 status", vint_status_o, e.st);
      chk("R11 irq", vint_irq_o, e.irq);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a[2:0]; reg_wdata = d[15:0];
    @(posedge clk);
    #1;
    case (a)
      0: begin mht = d & 'hff; mha = (d >> 8) & 'hff; end
      1: begin mhs = d & 'hff; mhw = (d >> 12) & 'hf; end
      2: mva = d & 'hfff;
      3: mvt = d & 'hfff;
      4: begin mvs = d & 'hfff; mvw = (d >> 12) & 'hf; end
      5: begin mih = d[0]; miv = d[1]; mie = d[2]; mrun = d[3];
               if (!mrun) begin mpx = 0; mhc = 0; mlc = 0; end end
      6: if (!d[0]) mst = 0;
      default: ;
    endcase
    q.push_back(model_out());
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pix_ce = 1'b1;
      @(posedge clk); #1;
      advance();
      q.push_back(model_out());
      if (de_o) de_cnt++;
      if (hsync_o) hs_cnt++;
      if (vsync_o) vs_cnt++;
      @(negedge clk); pix_ce = 1'b0;
      @(posedge clk); #1;
      q.push_back(model_out());
    end
  endtask

  task automatic clear_counts();
    de_cnt = 0; hs_cnt = 0; vs_cnt = 0;
  endtask

  task automatic ticks_to_status(output int n);
    n = 0;
    while (!vint_status_o && n < 2000) begin tick(1); n++; end
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; pix_ce = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 de", de_o, 0);
    chk("R1 hsync", hsync_o, 0);
    chk("R1 vsync", vsync_o, 0);
    chk("R1 status", vint_status_o, 0);
    chk("R1 irq", vint_irq_o, 0);
    @(negedge clk); rst_n = 1'b1;

    // geometry A: 6 chars total, 3 active, hsync char 4 width 1;
    // 8 lines total, 4 active, vsync lines 5..6
    wr(0, 16'h0205);
    wr(1, 16'h0003);
    wr(2, 3);
    wr(3, 7);
    wr(4, 16'h1004);
    wr(5, 16'h0003);                       // inverted syncs, not running
    chk("R8 idle hsync inverted", hsync_o, 1);
    chk("R8 idle vsync inverted", vsync_o, 1);
    chk("R12 idle de", de_o, 0);

    wr(5, 16'h000C);                       // run, irq enabled
    ticks_to_status(n);
    chk("R9 ticks to first retrace A", n, 240);
    chk("R11 irq follows status", vint_irq_o, 1);
    clear_counts();
    tick(384);
    chk("R3/R5 active pixels per frame A", de_cnt, 96);
    chk("R4 hsync pixels per frame A", hs_cnt, 64);
    chk("R6 vsync pixels per frame A", vs_cnt, 96);

    // idle mid-line inside the active window
    tick(144 + 23);
    chk("R2 de before idle", de_o, 1);
    repeat (40) @(posedge clk);
    #1;
    chk("R2 de holds without pix_ce", de_o, 1);
    tick(1);
    chk("R2/R3 active ends after 3 chars", de_o, 0);

    wr(6, 16'h0001);
    chk("R10 write with bit0=1 keeps status", vint_status_o, 1);
    wr(6, 16'h0000);
    chk("R10 write with bit0=0 clears status", vint_status_o, 0);
    chk("R11 irq drops with status", vint_irq_o, 0);

    wr(5, 16'h0008);                       // run, irq disabled
    tick(384);
    chk("R9 status set again", vint_status_o, 1);
    chk("R11 irq masked", vint_irq_o, 0);
    wr(5, 16'h000C);
    chk("R11 irq enabled", vint_irq_o, 1);

    wr(5, 16'h000B);                       // run, both syncs inverted
    clear_counts();
    tick(384);
    chk("R8 hsync low pixels inverted", 384 - hs_cnt, 64);
    chk("R8 vsync low pixels inverted", 384 - vs_cnt, 96);

    // geometry B: 4 chars total, 2 active, hsync chars 2..3;
    // 5 lines total, 3 active, vsync line 3
    wr(5, 16'h0000);
    wr(0, 16'h0103);
    wr(1, 16'h1001);
    wr(2, 2);
    wr(3, 4);
    wr(4, 16'h0002);
    wr(6, 16'h0000);
    wr(5, 16'h000C);
    chk("R7 de at origin", de_o, 1);
    ticks_to_status(n);
    chk("R9 ticks to first retrace B", n, 96);
    tick(64);
    clear_counts();
    tick(160);
    chk("R3/R5 active pixels per frame B", de_cnt, 48);
    chk("R4 hsync pixels per frame B", hs_cnt, 80);
    chk("R6 vsync pixels per frame B", vs_cnt, 32);

    // stop mid-frame, then restart from the origin
    tick(20);
    wr(5, 16'h0004);
    chk("R12 stopped de", de_o, 0);
    chk("R12 stopped hsync", hsync_o, 0);
    chk("R12 stopped vsync", vsync_o, 0);
    tick(10);
    chk("R12 stays idle with pix_ce", de_o, 0);
    wr(6, 16'h0000);
    wr(5, 16'h000C);
    ticks_to_status(n);
    chk("R12 restart at origin", n, 96);

    repeat (4) @(posedge clk);
    #1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule